// File: doc/BRIEF.md
# Checkerboard and Gradient Test Pattern Source

This block makes 24-bit test pixels for a video path. Its timing comes from an external vertical sync and data enable source. A 2-bit mode selects one of three behaviours. The generator can be off, in which case an external video stream passes through. It can produce a checkerboard of two programmable colours, or a horizontal intensity ramp. The mode is captured only in a cycle where vertical sync is high, so a frame is never split between two behaviours.

In checkerboard mode, every line is built from alternating runs. A run of colour A lasts its own programmable number of pixels, and a run of colour B lasts another. A line counter decides which colour opens each line: after a programmable number of lines the opening colour swaps, and vertical sync sets it back to A. In gradient mode, every active pixel adds a programmable step to an 8-bit level that starts at zero on each line. The level drives all three channels. Every output is registered, one cycle after its inputs.

Top module: `tps_top`

## Requirements
- R1: While reset is high, at the following edge pix_o becomes 0, pix_valid_o becomes 0, the captured mode becomes disabled and the opening colour becomes A.
- R2: The mode encoding is 0 = disabled, 1 = checkerboard, 2 = gradient, and 3 behaves as disabled. When disabled, pix_o and pix_valid_o equal ext_pix_i and ext_valid_i one cycle earlier.
- R3: mode_i is captured only at an edge where vs_i is high. At every other edge the captured mode holds.
- R4: In checkerboard and gradient modes, pix_valid_o equals de_i one cycle earlier and ext_pix_i and ext_valid_i are ignored. When de_i was low, pix_o is 0.
- R5: Checkerboard lines are made of alternating runs of rep_a_i pixels of color_a_i and rep_b_i pixels of color_b_i. The first run is of the colour given by the line's opening phase. Colour words reach pix_o unchanged, in byte order blue [23:16], green [15:8], red [7:0].
- R6: A repeat count of 0 acts as 1, and an alternate-line count of 0 acts as 1.
- R7: Each line starts with a full run of its opening colour. A falling edge of de_i ends a line. After alt_lines_i completed lines, the opening colour swaps between A and B.
- R8: An edge with vs_i high sets the opening colour to A and clears the line count. This still holds when that edge is also a line end.
- R9: In gradient mode, the first pixel of a line has level 0. Each later active pixel adds grad_step_i modulo 256, and all three channels carry the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vs_i | input | 1 | Vertical sync; mode capture and phase restart |
| de_i | input | 1 | Data enable; high on active pixels |
| mode_i | input | 2 | Requested mode (0 off, 1 checker, 2 gradient) |
| color_a_i | input | 24 | Checker colour A, blue-green-red bytes |
| color_b_i | input | 24 | Checker colour B, blue-green-red bytes |
| rep_a_i | input | 8 | Run length of colour A in pixels |
| rep_b_i | input | 8 | Run length of colour B in pixels |
| alt_lines_i | input | 8 | Lines between swaps of the opening colour |
| grad_step_i | input | 8 | Gradient increment per active pixel |
| ext_pix_i | input | 24 | External pixel for pass-through |
| ext_valid_i | input | 1 | External pixel valid |
| pix_o | output | 24 | Output pixel |
| pix_valid_o | output | 1 | Output pixel valid |

## Verification
Two things can happen at the same clock edge. Vertical sync can rise in the cycle where data enable falls, so the reset of the opening phase meets the line-end phase swap. Vertical sync also captures a new mode in that cycle. The bench sets an alternate count of 1 and raises vs_i in the very cycle after the last active pixel. The next line must then open with colour A. If the swap were allowed to win, it would open with B. Mode capture is judged by driving a new mode without vertical sync and confirming that pass-through continues until the sync pulse.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int TPS_CHAN_W = 8;
    localparam int TPS_NCHAN  = 3;
    localparam int TPS_PIX_W  = TPS_CHAN_W * TPS_NCHAN;
    localparam int TPS_CNT_W  = 8;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_CHECKER  = 2'd1,
        MODE_GRADIENT = 2'd2,
        MODE_RSVD     = 2'd3
    } tps_mode_e;

    typedef struct packed {
        logic [TPS_CHAN_W-1:0] blue;
        logic [TPS_CHAN_W-1:0] green;
        logic [TPS_CHAN_W-1:0] red;
    } tps_bgr_t;

    typedef struct packed {
        logic     valid;
        tps_bgr_t pix;
    } tps_beat_t;

    function automatic logic tps_is_pattern(input tps_mode_e m);
        return (m == MODE_CHECKER) || (m == MODE_GRADIENT);
    endfunction

endpackage

// File: rtl/tps_line_track.sv
module tps_line_track #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vs_i,
    input  logic             de_i,
    input  logic [CNT_W-1:0] alt_lines_i,
    output logic             line_start_o,
    output logic             line_phase_o
);
    logic             de_q;
    logic             line_end;
    logic [CNT_W-1:0] line_cnt;
    logic [CNT_W-1:0] alt_eff;
    logic [CNT_W:0]   cnt_nx;

    assign line_start_o = de_i && !de_q;
    assign line_end     = de_q && !de_i;
    assign alt_eff      = (alt_lines_i == '0) ? CNT_W'(1) : alt_lines_i;
    assign cnt_nx       = {1'b0, line_cnt} + (CNT_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q         <= 1'b0;
            line_cnt     <= '0;
            line_phase_o <= 1'b0;
        end else begin
            de_q <= de_i;
            if (vs_i) begin
                line_cnt     <= '0;
                line_phase_o <= 1'b0;
            end else if (line_end) begin
                if (cnt_nx >= {1'b0, alt_eff}) begin
                    line_cnt     <= '0;
                    line_phase_o <= ~line_phase_o;
                end else begin
                    line_cnt <= cnt_nx[CNT_W-1:0];
                end
            end
        end
    end

    // R8: sync forces phase A even on a line-end edge
    a_r8_vs_phase_a: assert property (@(posedge clk) disable iff (rst)
        vs_i |=> !line_phase_o);

    // R7: the opening phase moves only on a line end
    a_r7_phase_at_line_end: assert property (@(posedge clk) disable iff (rst)
        (!line_end && !vs_i) |=> $stable(line_phase_o));

endmodule

// File: rtl/tps_checker_run.sv
module tps_checker_run #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             de_i,
    input  logic             line_start_i,
    input  logic             line_phase_i,
    input  logic [CNT_W-1:0] len_a_i,
    input  logic [CNT_W-1:0] len_b_i,
    output logic             sel_b_o
);
    logic             cur_b;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] len_sel;
    logic [CNT_W:0]   pos_nx;
    logic             run_last;

    always_comb begin
        sel_b_o  = line_start_i ? line_phase_i : cur_b;
        pos      = line_start_i ? '0 : run_cnt;
        len_sel  = sel_b_o ? len_b_i : len_a_i;
        lim      = (len_sel == '0) ? CNT_W'(1) : len_sel;
        pos_nx   = {1'b0, pos} + (CNT_W+1)'(1);
        run_last = pos_nx >= {1'b0, lim};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_b   <= 1'b0;
            run_cnt <= '0;
        end else if (de_i) begin
            if (run_last) begin
                cur_b   <= ~sel_b_o;
                run_cnt <= '0;
            end else begin
                cur_b   <= sel_b_o;
                run_cnt <= pos_nx[CNT_W-1:0];
            end
        end
    end

    // R5: the colour swaps right after the last pixel of a run
    a_r5_swap_after_run: assert property (@(posedge clk) disable iff (rst)
        (de_i && run_last) |=> (!de_i || sel_b_o != $past(sel_b_o)));

    // R5: inside a run the colour holds
    a_r5_hold_in_run: assert property (@(posedge clk) disable iff (rst)
        (de_i && !run_last) |=> (!de_i || sel_b_o == $past(sel_b_o)));

endmodule

// File: rtl/tps_gradient.sv
module tps_gradient #(
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              de_i,
    input  logic              line_start_i,
    input  logic [CHAN_W-1:0] step_i,
    output logic [CHAN_W-1:0] level_o
);
    logic [CHAN_W-1:0] acc;

    assign level_o = line_start_i ? '0 : acc;

    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (de_i) acc <= level_o + step_i;
    end

endmodule

// File: rtl/tps_top.sv
module tps_top
    import tps_pkg::*;
#(
    parameter int CHAN_W = tps_pkg::TPS_CHAN_W,
    parameter int NCHAN  = tps_pkg::TPS_NCHAN,
    parameter int CNT_W  = tps_pkg::TPS_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vs_i,
    input  logic                    de_i,
    input  logic [1:0]              mode_i,
    input  logic [CHAN_W*NCHAN-1:0] color_a_i,
    input  logic [CHAN_W*NCHAN-1:0] color_b_i,
    input  logic [CNT_W-1:0]        rep_a_i,
    input  logic [CNT_W-1:0]        rep_b_i,
    input  logic [CNT_W-1:0]        alt_lines_i,
    input  logic [CHAN_W-1:0]       grad_step_i,
    input  logic [CHAN_W*NCHAN-1:0] ext_pix_i,
    input  logic                    ext_valid_i,
    output logic [CHAN_W*NCHAN-1:0] pix_o,
    output logic                    pix_valid_o
);
    localparam int PIX_W = CHAN_W * NCHAN;

    tps_mode_e         mode_q;
    logic              line_start;
    logic              line_phase;
    logic              sel_b;
    logic [CHAN_W-1:0] level;
    logic [PIX_W-1:0]  grad_pix;
    logic [PIX_W-1:0]  nxt_pix;
    logic              nxt_valid;

    tps_line_track #(.CNT_W(CNT_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .vs_i         (vs_i),
        .de_i         (de_i),
        .alt_lines_i  (alt_lines_i),
        .line_start_o (line_start),
        .line_phase_o (line_phase)
    );

    tps_checker_run #(.CNT_W(CNT_W)) u_chk (
        .clk          (clk),
        .rst          (rst),
        .de_i         (de_i),
        .line_start_i (line_start),
        .line_phase_i (line_phase),
        .len_a_i      (rep_a_i),
        .len_b_i      (rep_b_i),
        .sel_b_o      (sel_b)
    );

    tps_gradient #(.CHAN_W(CHAN_W)) u_grad (
        .clk          (clk),
        .rst          (rst),
        .de_i         (de_i),
        .line_start_i (line_start),
        .step_i       (grad_step_i),
        .level_o      (level)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_gray
        assign grad_pix[c*CHAN_W +: CHAN_W] = level;
    end

    always_comb begin
        unique case (mode_q)
            MODE_CHECKER: begin
                nxt_valid = de_i;
                nxt_pix   = de_i ? (sel_b ? color_b_i : color_a_i) : '0;
            end
            MODE_GRADIENT: begin
                nxt_valid = de_i;
                nxt_pix   = de_i ? grad_pix : '0;
            end
            default: begin
                nxt_valid = ext_valid_i;
                nxt_pix   = ext_pix_i;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_OFF;
            pix_o       <= '0;
            pix_valid_o <= 1'b0;
        end else begin
            if (vs_i) mode_q <= tps_mode_e'(mode_i);
            pix_o       <= nxt_pix;
            pix_valid_o <= nxt_valid;
        end
    end

    // R1: reset clears the output stage
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!pix_valid_o && pix_o == '0));

    // R3: the captured mode moves only on sync
    a_r3_mode_on_vs: assert property (@(posedge clk) disable iff (rst)
        !vs_i |=> $stable(mode_q));

    // R2: pass-through when disabled or reserved
    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        !tps_is_pattern(mode_q) |=>
            (pix_o == $past(ext_pix_i) && pix_valid_o == $past(ext_valid_i)));

    // R4: generated valid follows data enable
    a_r4_valid_tracks_de: assert property (@(posedge clk) disable iff (rst)
        tps_is_pattern(mode_q) |=> (pix_valid_o == $past(de_i)));

    // R9: the ramp opens each line at zero
    a_r9_line_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_GRADIENT && line_start) |=> (pix_o == '0));

    // R9: all three channels carry the same level
    a_r9_gray_channels: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_GRADIENT) |=>
            (pix_o[PIX_W-1 -: CHAN_W] == pix_o[CHAN_W-1:0]
             && pix_o[2*CHAN_W-1 -: CHAN_W] == pix_o[CHAN_W-1:0]));

endmodule

// File: tb/tb_tps_top.sv
`timescale 1ns/1ps
module tb_tps_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        vs_i, de_i;
    logic [1:0]  mode_i;
    logic [23:0] color_a_i, color_b_i, ext_pix_i, pix_o;
    logic [7:0]  rep_a_i, rep_b_i, alt_lines_i, grad_step_i;
    logic        ext_valid_i, pix_valid_o;

    int checks = 0;
    int failures = 0;
    int line_idx = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tps_top dut (
        .clk(clk), .rst(rst), .vs_i(vs_i), .de_i(de_i), .mode_i(mode_i),
        .color_a_i(color_a_i), .color_b_i(color_b_i),
        .rep_a_i(rep_a_i), .rep_b_i(rep_b_i), .alt_lines_i(alt_lines_i),
        .grad_step_i(grad_step_i), .ext_pix_i(ext_pix_i),
        .ext_valid_i(ext_valid_i), .pix_o(pix_o), .pix_valid_o(pix_valid_o)
    );

    task automatic chk(input string req, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge; outputs are ready at the next one
    task automatic cyc(input logic de, input logic vs, input logic [23:0] ep, input logic ev);
        de_i = de; vs_i = vs; ext_pix_i = ep; ext_valid_i = ev;
        @(negedge clk);
    endtask

    function automatic int eff(input logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic vs_pulse(input logic [1:0] m);
        mode_i = m;
        cyc(1'b0, 1'b1, 24'h0, 1'b0);
        line_idx = 0;
    endtask

    task automatic blank(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b0, 24'h123456, 1'b1);
            chk(req, {pix_valid_o, pix_o}, 25'h0);
        end
    endtask

    task automatic checker_line(input string req, input int n);
        int ph, ra, rb, q, first;
        logic sb;
        ra = eff(rep_a_i); rb = eff(rep_b_i);
        ph = (line_idx / eff(alt_lines_i)) % 2;
        for (int p = 0; p < n; p++) begin
            cyc(1'b1, 1'b0, 24'hA5A5A5 ^ 24'(p), p[0]);
            q = p % (ra + rb);
            first = (ph != 0) ? rb : ra;
            sb = (q < first) ? (ph != 0) : (ph == 0);
            chk(req, {pix_valid_o, pix_o}, {1'b1, sb ? color_b_i : color_a_i});
        end
        line_idx++;
    endtask

    task automatic t_reset();
        rst = 1'b1; vs_i = 0; de_i = 0; mode_i = 2'd1;
        color_a_i = 24'hFECC00; color_b_i = 24'h006AA7;
        rep_a_i = 8'd3; rep_b_i = 8'd2; alt_lines_i = 8'd2; grad_step_i = 8'h10;
        ext_pix_i = 24'hFFFFFF; ext_valid_i = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 reset output", {pix_valid_o, pix_o}, 25'h0);
        rst = 1'b0;
        // mode captured as disabled: pass-through with no sync
        cyc(1'b1, 1'b0, 24'h0BCDEF, 1'b1);
        chk("R1 mode off after reset", {pix_valid_o, pix_o}, {1'b1, 24'h0BCDEF});
    endtask

    task automatic t_passthrough();
        vs_pulse(2'd0);
        for (int i = 0; i < 4; i++) begin
            cyc(i[1], 1'b0, 24'(i * 24'h010203 + 24'h111), i[0]);
            chk("R2 off pass", {pix_valid_o, pix_o}, {i[0], 24'(i * 24'h010203 + 24'h111)});
        end
        vs_pulse(2'd3);
        cyc(1'b1, 1'b0, 24'h777777, 1'b0);
        chk("R2 reserved pass", {pix_valid_o, pix_o}, {1'b0, 24'h777777});
    endtask

    task automatic t_mode_latch();
        vs_pulse(2'd0);
        mode_i = 2'd1;
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 24'h00AA00 + 24'(i), 1'b1);
            chk("R3 no sync no change", {pix_valid_o, pix_o}, {1'b1, 24'h00AA00 + 24'(i)});
        end
        blank("R3 blank", 0);
        cyc(1'b0, 1'b0, 24'h0, 1'b0);
        vs_pulse(2'd1);
        checker_line("R3 after sync", 4);
        blank("R4 blank zero", 2);
    endtask

    task automatic t_checker();
        rep_a_i = 8'd3; rep_b_i = 8'd2; alt_lines_i = 8'd2;
        vs_pulse(2'd1);
        for (int l = 0; l < 5; l++) begin
            checker_line("R5 R7 checker", 12);
            blank("R4 blank", 3);
        end
    endtask

    task automatic t_zero_counts();
        rep_a_i = 8'd0; rep_b_i = 8'd0; alt_lines_i = 8'd0;
        vs_pulse(2'd1);
        for (int l = 0; l < 3; l++) begin
            checker_line("R6 zero as one", 6);
            blank("R6 blank", 2);
        end
    endtask

    task automatic t_vs_collision();
        rep_a_i = 8'd4; rep_b_i = 8'd4; alt_lines_i = 8'd1;
        vs_pulse(2'd1);
        checker_line("R8 pre line", 5);
        // line end and sync on the same edge
        cyc(1'b0, 1'b1, 24'h0, 1'b0);
        line_idx = 0;
        cyc(1'b0, 1'b0, 24'h0, 1'b0);
        cyc(1'b1, 1'b0, 24'h0, 1'b0);
        chk("R8 sync beats line end", {pix_valid_o, pix_o}, {1'b1, color_a_i});
        cyc(1'b0, 1'b0, 24'h0, 1'b0);
        line_idx = 1;
        checker_line("R7 next line opens B", 3);
        blank("R7 blank", 2);
    endtask

    task automatic t_gradient();
        grad_step_i = 8'h30;
        vs_pulse(2'd2);
        for (int l = 0; l < 2; l++) begin
            for (int p = 0; p < 10; p++) begin
                logic [7:0] lv;
                lv = 8'(p * 8'h30);
                cyc(1'b1, 1'b0, 24'hFFFFFF, 1'b1);
                chk("R9 ramp", {pix_valid_o, pix_o}, {1'b1, lv, lv, lv});
            end
            blank("R4 gradient blank", 2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_passthrough();
        t_mode_latch();
        t_checker();
        t_zero_counts();
        t_vs_collision();
        t_gradient();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule